// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Unit

This block sits beside a BCD timekeeping core and watches its live seconds, minutes, hours and day/date values. It holds one byte of alarm setting for each of those four fields. Bit 7 of each byte is a mask bit: a masked field is left out of the comparison. The comparison runs only when the timekeeping core pulses its once-per-second tick. When every field that is not masked equals the live time at that tick, an alarm flag is set. Setting a mask bit in the day/date byte turns the alarm into a daily alarm that fires at the same hour, minute and second every day.

The flag is set whether or not the alarm interrupt is enabled. Software arms and clears the alarm through two separate bits. Clearing the flag releases the interrupt and leaves the alarm armed for the next match. Clearing the enable releases the interrupt and blocks later interrupts, but the flag still records matches. A single active-low output pin is shared. A control bit chooses whether it carries the alarm interrupt or the square wave supplied by the timekeeping core.

The alarm bytes have no reset value, because the alarm storage is not cleared at power-up. Software writes all of them before it enables the alarm. The registers are reached through a simple synchronous write / combinational read bus.

Top module: `tod_alarm_unit`

## Requirements
- R1: Register map on the 3-bit address: 0 alarm seconds, 1 alarm minutes, 2 alarm hours, 3 alarm day/date, 4 control, 5 status. A write to an alarm byte stores all 8 bits, and a read of that address returns them unchanged.
- R2: After reset, control and status read 00h. The alarm bytes are not reset.
- R3: At a cycle where `tick_1hz` is 1, status bit 0 (the alarm flag) becomes 1 in the next cycle if, for every alarm byte whose bit 7 is 0, bits 6:0 equal bits 6:0 of the matching live-time input. This holds whatever the interrupt enable is.
- R4: A field whose alarm byte has bit 7 = 1 is ignored. Day/date byte 80h gives a daily alarm that matches on any day. With all four bytes at 80h, every tick sets the flag.
- R5: Hours are compared on bits 6:0, so the 12-hour select (bit 6) and the PM bit (bit 5) must also match. Alarm hours 45h (5 AM, 12-hour) does not match live hours 65h (5 PM) or 05h (24-hour 05).
- R6: When control bit 2 = 1, `irq_sqw_n` is 0 exactly when the flag = 1 and control bit 0 (interrupt enable) = 1. Otherwise it is 1.
- R7: Writing status with bit 0 = 0 clears the flag and releases the interrupt. Writing bit 0 = 1 leaves the flag unchanged. A later match sets the flag again.
- R8: Writing control bit 0 = 0 releases the interrupt at once and keeps the flag. Later matches set the flag but do not assert the output.
- R9: The flag changes only at ticks or by a status write. A matching time with no tick does not set it. A flag cleared during a matching second stays clear until the next matching tick.
- R10: When control bit 2 = 0, `irq_sqw_n` follows `sqw_in`.
- R11: A tick that matches and a flag-clearing status write in the same cycle leave the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of control and status |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tick_1hz | input | 1 | One-cycle pulse at each seconds update |
| now_sec | input | 8 | Live BCD seconds |
| now_min | input | 8 | Live BCD minutes |
| now_hour | input | 8 | Live BCD hours with mode and PM bits |
| now_day | input | 8 | Live BCD day/date |
| sqw_in | input | 1 | Square wave from the timekeeping core |
| irq_sqw_n | output | 1 | Shared active-low interrupt / square-wave pin |

## Verification
The alarm is set to 5:30:00 AM in 12-hour form with a daily mask. Ticks are then applied at live times that each differ from it in one field: seconds, minutes, the PM bit, the 12-hour select, or the day value. This shows which fields take part in the compare and which are masked. An all-masked setting checks that masking really removes fields. Flag clears, enable clears and output-select changes are applied around matching and non-matching ticks. This separates flag state from pin state. A matching time held without a tick, and a clear placed in the same cycle as a matching tick, pin down when the flag can change.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    localparam int DW       = 8;
    localparam int NFIELD   = 4;
    localparam int AW       = 3;
    localparam int MASK_BIT = 7;
    localparam int EN_BIT   = 0;
    localparam int SEL_BIT  = 2;
    localparam int FLAG_BIT = 0;

    localparam logic [AW-1:0] ADR_SEC  = 3'd0;
    localparam logic [AW-1:0] ADR_MIN  = 3'd1;
    localparam logic [AW-1:0] ADR_HOUR = 3'd2;
    localparam logic [AW-1:0] ADR_DAY  = 3'd3;
    localparam logic [AW-1:0] ADR_CTRL = 3'd4;
    localparam logic [AW-1:0] ADR_STAT = 3'd5;

    typedef struct packed {
        logic irq_en;
        logic out_sel;
    } ctrl_t;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
#(
    parameter int W  = DW,
    parameter int NF = NFIELD,
    parameter int A  = AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [A-1:0]  addr,
    input  logic [W-1:0]  wdata,
    input  logic          flag,
    output logic [W-1:0]  rdata,
    output logic [NF*W-1:0] alarm_flat,
    output ctrl_t         ctrl,
    output logic          flag_clr
);
    logic [W-1:0] alm_q [NF];
    logic [W-1:0] alm_d [NF];
    ctrl_t        ctrl_q, ctrl_d;

    always_comb begin
        for (int i = 0; i < NF; i++) begin
            alm_d[i] = alm_q[i];
            if (we && (int'(addr) == i))
                alm_d[i] = wdata;
        end
        ctrl_d = ctrl_q;
        if (we && addr == ADR_CTRL) begin
            ctrl_d.irq_en  = wdata[EN_BIT];
            ctrl_d.out_sel = wdata[SEL_BIT];
        end
    end

    // alarm storage deliberately carries no reset
    always_ff @(posedge clk) begin
        for (int i = 0; i < NF; i++)
            alm_q[i] <= alm_d[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign flag_clr = we && (addr == ADR_STAT) && !wdata[FLAG_BIT];
    assign ctrl     = ctrl_q;

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_flat
            assign alarm_flat[g*W +: W] = alm_q[g];
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (int'(addr) < NF) begin
            rdata = alm_q[addr[1:0]];
        end else if (addr == ADR_CTRL) begin
            rdata[EN_BIT]  = ctrl_q.irq_en;
            rdata[SEL_BIT] = ctrl_q.out_sel;
        end else if (addr == ADR_STAT) begin
            rdata[FLAG_BIT] = flag;
        end
    end

    // R8: a control write that drops the enable takes effect next cycle
    p_en_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_CTRL && !wdata[EN_BIT]) |=> !ctrl.irq_en);
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
#(
    parameter int W  = DW,
    parameter int NF = NFIELD,
    parameter int MB = MASK_BIT
) (
    input  logic [NF*W-1:0] alarm_flat,
    input  logic [NF*W-1:0] now_flat,
    output logic            match
);
    logic [NF-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_fld
            logic [W-1:0] a_b, n_b;
            assign a_b    = alarm_flat[g*W +: W];
            assign n_b    = now_flat[g*W +: W];
            assign hit[g] = a_b[MB] || (a_b[MB-1:0] == n_b[MB-1:0]);
        end
    endgenerate

    assign match = &hit;
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag
    import tod_alarm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  match,
    input  logic  clr,
    input  ctrl_t ctrl,
    input  logic  sqw_in,
    output logic  flag,
    output logic  irq_n
);
    typedef struct packed { logic flag; } st_t;
    st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr)           st_d.flag = 1'b0;
        if (tick && match) st_d.flag = 1'b1;   // R11: set wins over clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag  = st_q.flag;
    assign irq_n = ctrl.out_sel ? !(st_q.flag && ctrl.irq_en) : sqw_in;

    p_set_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match) |=> flag);
    p_no_set_off_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !tick) |=> !flag);
    p_hold_until_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    p_clr_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !tick) |=> !flag);
endmodule

// File: rtl/tod_alarm_unit.sv
module tod_alarm_unit
    import tod_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_we,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       tick_1hz,
    input  logic [7:0] now_sec,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_day,
    input  logic       sqw_in,
    output logic       irq_sqw_n
);
    localparam int FW = NFIELD * DW;

    logic [FW-1:0] alarm_flat, now_flat;
    ctrl_t         ctrl;
    logic          flag_clr, flag, match;

    assign now_flat = {now_day, now_hour, now_min, now_sec};

    tod_alarm_regs #(.W(DW), .NF(NFIELD), .A(AW)) u_regs (
        .clk, .rst_n,
        .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .flag, .rdata(bus_rdata),
        .alarm_flat, .ctrl, .flag_clr
    );

    tod_alarm_match #(.W(DW), .NF(NFIELD), .MB(MASK_BIT)) u_match (
        .alarm_flat, .now_flat, .match
    );

    tod_alarm_flag u_flag (
        .clk, .rst_n,
        .tick(tick_1hz), .match, .clr(flag_clr),
        .ctrl, .sqw_in, .flag, .irq_n(irq_sqw_n)
    );

    // R8: dropping the enable with the interrupt routed releases the pin
    p_en_clear_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADR_CTRL && !bus_wdata[EN_BIT] && bus_wdata[SEL_BIT])
        |=> irq_sqw_n);
endmodule

// File: tb/tb_tod_alarm_unit.sv
module tb_tod_alarm_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_1hz = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_day = '0;
    logic       sqw_in = 1'b0;
    logic       irq_sqw_n;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_alarm_unit dut (.*);

    // {sec, min, hour, day, expected flag}
    localparam logic [32:0] VEC [8] = '{
        {8'h00, 8'h30, 8'h45, 8'h12, 1'b1},
        {8'h00, 8'h30, 8'h45, 8'h03, 1'b1},
        {8'h01, 8'h30, 8'h45, 8'h12, 1'b0},
        {8'h00, 8'h31, 8'h45, 8'h12, 1'b0},
        {8'h00, 8'h30, 8'h65, 8'h12, 1'b0},
        {8'h00, 8'h30, 8'h05, 8'h12, 1'b0},
        {8'h00, 8'h29, 8'h45, 8'h01, 1'b0},
        {8'h59, 8'h30, 8'h45, 8'h31, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input logic [7:0] s, m, h, dd);
        @(negedge clk);
        now_sec = s; now_min = m; now_hour = h; now_day = dd;
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_alarm(input logic [7:0] s, m, h, dd);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, dd);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got 00 expected 01");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(3'd4, r); chk("R2 control after reset", r, 8'h00);
        rd(3'd5, r); chk("R2 status after reset", r, 8'h00);
        // R10 reset selects square wave
        sqw_in = 1'b1; #1 chk("R10 pin follows sqw high", {7'b0, irq_sqw_n}, 8'h01);
        sqw_in = 1'b0; #1 chk("R10 pin follows sqw low", {7'b0, irq_sqw_n}, 8'h00);

        // R1 readback
        set_alarm(8'h00, 8'h30, 8'h45, 8'h80);
        rd(3'd0, r); chk("R1 alarm sec", r, 8'h00);
        rd(3'd1, r); chk("R1 alarm min", r, 8'h30);
        rd(3'd2, r); chk("R1 alarm hour", r, 8'h45);
        rd(3'd3, r); chk("R1 alarm day", r, 8'h80);

        // interrupt routed, enable off
        wr(3'd4, 8'h04);
        rd(3'd4, r); chk("R1 control readback", r, 8'h04);

        // vector table: R3 R4 R5
        foreach (VEC[i]) begin
            wr(3'd5, 8'h00);
            tick(VEC[i][32:25], VEC[i][24:17], VEC[i][16:9], VEC[i][8:1]);
            rd(3'd5, r);
            chk($sformatf("R3/R4/R5 vector %0d flag", i), r, {7'b0, VEC[i][0]});
            chk($sformatf("R6 vector %0d pin high with enable off", i), {7'b0, irq_sqw_n}, 8'h01);
        end

        // R6 enable asserts pin
        wr(3'd5, 8'h00);
        wr(3'd4, 8'h05);
        chk("R6 no flag pin high", {7'b0, irq_sqw_n}, 8'h01);
        tick(8'h00, 8'h30, 8'h45, 8'h07);
        chk("R6 pin low on enabled match", {7'b0, irq_sqw_n}, 8'h00);

        // R10 with flag set, square wave selected
        wr(3'd4, 8'h01);
        sqw_in = 1'b1; #1 chk("R10 sqw passes with flag pending", {7'b0, irq_sqw_n}, 8'h01);
        sqw_in = 1'b0;
        wr(3'd4, 8'h05);
        chk("R6 pin low again", {7'b0, irq_sqw_n}, 8'h00);

        // R7 write 1 keeps flag, write 0 clears
        wr(3'd5, 8'h01);
        rd(3'd5, r); chk("R7 write one keeps flag", r, 8'h01);
        wr(3'd5, 8'h00);
        rd(3'd5, r); chk("R7 clear flag", r, 8'h00);
        chk("R7 pin released", {7'b0, irq_sqw_n}, 8'h01);
        // R9 matching time held, no tick
        repeat (5) @(negedge clk);
        rd(3'd5, r); chk("R9 no set without tick", r, 8'h00);
        wr(3'd5, 8'h01);
        rd(3'd5, r); chk("R7 write one does not set", r, 8'h00);
        // R7 still armed next day
        tick(8'h00, 8'h30, 8'h45, 8'h08);
        chk("R7 rearmed pin low", {7'b0, irq_sqw_n}, 8'h00);

        // R8 enable clear
        wr(3'd4, 8'h04);
        chk("R8 pin released", {7'b0, irq_sqw_n}, 8'h01);
        rd(3'd5, r); chk("R8 flag kept", r, 8'h01);
        wr(3'd5, 8'h00);
        tick(8'h00, 8'h30, 8'h45, 8'h09);
        rd(3'd5, r); chk("R8 flag still sets", r, 8'h01);
        chk("R8 pin stays high", {7'b0, irq_sqw_n}, 8'h01);

        // R11 set beats clear in same cycle
        @(negedge clk);
        now_sec = 8'h00; now_min = 8'h30; now_hour = 8'h45; now_day = 8'h10;
        tick_1hz = 1'b1; bus_we = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h00;
        @(negedge clk);
        tick_1hz = 1'b0; bus_we = 1'b0;
        rd(3'd5, r); chk("R11 set wins over clear", r, 8'h01);

        // R4 all masked
        wr(3'd5, 8'h00);
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        tick(8'h17, 8'h42, 8'h23, 8'h05);
        rd(3'd5, r); chk("R4 all masked fires", r, 8'h01);

        // R4 seconds-only unmasked
        wr(3'd5, 8'h00);
        set_alarm(8'h15, 8'h80, 8'h80, 8'h80);
        tick(8'h16, 8'h00, 8'h00, 8'h01);
        rd(3'd5, r); chk("R4 seconds mismatch", r, 8'h00);
        tick(8'h15, 8'h59, 8'h11, 8'h22);
        rd(3'd5, r); chk("R4 seconds match", r, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule